// File: doc/BRIEF.md
# Match-Compare Interval Timer

This block provides an interval timer for an operating system. A 32-bit up-counter runs continuously. Four match channels each hold a 32-bit compare value. On every tick the current counter value is compared with each channel's compare value. When they are equal, that channel raises a status flag, and the flag stays set until software clears it. A per-channel enable mask routes the flags to individual interrupt lines. A single OR line combines all of them.

Software reaches the block through a plain 32-bit register port. Writes take one clock cycle, and reads are combinational. Software can set the counter, reprogram any compare value, clear status flags by writing ones, and set the interrupt mask. A one-way arming bit lets channel 3 act as a watchdog. Once armed, a channel 3 match produces a one-cycle reset request.

The watchdog is a small state machine with three states. WD_OFF moves to WD_ARMED when software writes the arm bit. WD_ARMED moves to WD_FIRE on a channel 3 match. WD_FIRE always returns to WD_ARMED on the next cycle. Only system reset returns the machine to WD_OFF.

Top module: `match_timer`

## Requirements
- R1: After reset, all eight registers read 0, `irq_ch` and `irq_any` are 0, and `wd_reset_req` is 0.
- R2: The counter (read at byte address 0x10) increases by one on every clock edge where `tick_en` is 1. It holds its value on other edges. It wraps from 0xFFFFFFFF to 0.
- R3: A write to 0x10 loads the counter with the write data, and counting resumes from that value. If a load and a tick occur on the same edge, the load wins.
- R4: The compare values of channels 0 to 3 sit at 0x00, 0x04, 0x08 and 0x0C. They can be read back, and a new value is used from the next edge onward.
- R5: Status bit n (register 0x14, bits 3:0) is set on a tick edge where the counter equals compare value n. Only exact equality counts.
- R6: Writing 0x14 clears each status bit written as 1 and leaves bits written as 0 unchanged. If a match and a clear hit the same bit on the same edge, the bit is set.
- R7: `irq_ch[n]` equals status bit n AND enable bit n (register 0x1C, bits 3:0), and `irq_any` is the OR of `irq_ch`. Masking a channel does not change its status bit.
- R8: Writing 1 to bit 0 of 0x18 arms the watchdog, and bit 0 then reads 1. Writing 0 to that bit does not disarm it.
- R9: While the watchdog is armed, a channel 3 match raises `wd_reset_req` for exactly the one cycle after the match edge. While it is disarmed, a match leaves `wd_reset_req` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable, one per tick |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational on bus_addr |
| irq_ch | output | 4 | Per-channel masked interrupt |
| irq_any | output | 1 | OR of all channel interrupts |
| wd_reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
The assertions assume that `tick_en`, `bus_sel`, `bus_wr`, `bus_addr` and `bus_wdata` are settled before each rising edge. They also assume that a counter load is the only event that can break the plus-one step between ticks. The bench changes every input on the falling edge and reads on the low phase, so each stimulus meets one rising edge in a known state. The bench keeps the compare values far apart, so the only matches are the ones each scenario aims at.

// File: rtl/mt_pkg.sv
package mt_pkg;
    localparam int unsigned AW = 5;
    localparam logic [AW-1:0] A_COUNT  = 5'h10;
    localparam logic [AW-1:0] A_STATUS = 5'h14;
    localparam logic [AW-1:0] A_WDARM  = 5'h18;
    localparam logic [AW-1:0] A_MASK   = 5'h1C;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_ARMED = 2'd1,
        WD_FIRE  = 2'd2
    } wd_state_t;
endpackage

// File: rtl/mt_counter.sv
module mt_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (load)    count <= load_val;
        else if (tick_en) count <= count + W'(1);
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(count));
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load) |=> (count == $past(count) + W'(1)));
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));
endmodule

// File: rtl/mt_channel.sv
module mt_channel #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic [W-1:0] count,
    input  logic         wr_cmp,
    input  logic [W-1:0] wdata,
    input  logic         clr,
    output logic [W-1:0] cmp_q,
    output logic         flag,
    output logic         hit
);
    assign hit = tick_en && (count == cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (wr_cmp) cmp_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/mt_watchdog.sv
module mt_watchdog (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    input  logic hit,
    output logic armed,
    output logic req
);
    import mt_pkg::*;

    wd_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WD_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            WD_OFF:   if (arm_req) nxt = WD_ARMED;
            WD_ARMED: if (hit)     nxt = WD_FIRE;
            WD_FIRE:               nxt = WD_ARMED;
            default:               nxt = WD_OFF;
        endcase
    end

    always_comb begin
        armed = (state != WD_OFF);
        req   = (state == WD_FIRE);
    end

    p_arm_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
    p_fire_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(hit));
endmodule

// File: rtl/match_timer.sv
module match_timer #(
    parameter int unsigned W     = 32,
    parameter int unsigned NCH   = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         bus_sel,
    input  logic         bus_wr,
    input  logic [4:0]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    output logic [3:0]   irq_ch,
    output logic         irq_any,
    output logic         wd_reset_req
);
    import mt_pkg::*;

    localparam int unsigned WD_CH = NCH - 1;

    logic           wr_go;
    logic [W-1:0]   count;
    logic [W-1:0]   cmp_q [NCH];
    logic [NCH-1:0] flag, hit, wr_cmp, mask;
    logic           wd_armed;

    assign wr_go = bus_sel && bus_wr;

    mt_counter #(.W(W)) u_count (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .load(wr_go && bus_addr == A_COUNT),
        .load_val(bus_wdata), .count(count)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign wr_cmp[i] = wr_go && (bus_addr == 5'(4 * i));
        mt_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .count(count),
            .wr_cmp(wr_cmp[i]), .wdata(bus_wdata),
            .clr(wr_go && bus_addr == A_STATUS && bus_wdata[i]),
            .cmp_q(cmp_q[i]), .flag(flag[i]), .hit(hit[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                           mask <= '0;
        else if (wr_go && bus_addr == A_MASK) mask <= bus_wdata[NCH-1:0];
    end

    mt_watchdog u_wd (
        .clk(clk), .rst_n(rst_n),
        .arm_req(wr_go && bus_addr == A_WDARM && bus_wdata[0]),
        .hit(hit[WD_CH]), .armed(wd_armed), .req(wd_reset_req)
    );

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NCH; i++)
            if (bus_addr == 5'(4 * i)) bus_rdata = cmp_q[i];
        case (bus_addr)
            A_COUNT:  bus_rdata = count;
            A_STATUS: bus_rdata = 32'(flag);
            A_WDARM:  bus_rdata = 32'(wd_armed);
            A_MASK:   bus_rdata = 32'(mask);
            default:  ;
        endcase
    end

    assign irq_ch  = flag & mask;
    assign irq_any = |irq_ch;

    p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_any == (|(flag & mask))));
endmodule

// File: tb/match_timer_test.sv
module match_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_ch;
    logic        irq_any;
    logic        wd_reset_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    match_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_ch(irq_ch), .irq_any(irq_any),
        .wd_reset_req(wd_reset_req)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(5'(4 * a), d);
            check("R1 register", d, 0);
        end
        check("R1 irq", {27'd0, irq_any, irq_ch}, 0);
        check("R1 wd", 32'(wd_reset_req), 0);
    endtask

    task automatic t_compare_rw;
        logic [31:0] d;
        wr(5'h00, 32'h0001_0000);
        wr(5'h04, 32'h0002_0000);
        wr(5'h08, 32'h0003_0000);
        wr(5'h0C, 32'h0004_0000);
        for (int i = 0; i < 4; i++) begin
            rd(5'(4 * i), d);
            check("R4 readback", d, 32'h0001_0000 * (i + 1));
        end
    endtask

    task automatic t_counter;
        logic [31:0] d;
        wr(5'h10, 32'd100);
        rd(5'h10, d); check("R3 load", d, 100);
        repeat (3) @(negedge clk);
        rd(5'h10, d); check("R2 hold", d, 100);
        ticks(5);
        rd(5'h10, d); check("R2 step", d, 105);
        wr(5'h10, 32'hFFFF_FFFE);
        ticks(3);
        rd(5'h10, d); check("R2 wrap", d, 1);
        tick_en = 1'b1;
        wr(5'h10, 32'd500);
        tick_en = 1'b0;
        rd(5'h10, d); check("R3 load beats tick", d, 500);
        ticks(2);
        rd(5'h10, d); check("R3 resume", d, 502);
    endtask

    task automatic t_match;
        logic [31:0] d;
        wr(5'h14, 32'hF);
        wr(5'h04, 32'd1000);
        wr(5'h10, 32'd995);
        ticks(5);
        rd(5'h14, d); check("R5 no early set", d, 0);
        ticks(1);
        rd(5'h14, d); check("R5 set on equal", d, 32'h2);
        wr(5'h14, 32'h0);
        rd(5'h14, d); check("R6 zero write", d, 32'h2);
        wr(5'h14, 32'h1);
        rd(5'h14, d); check("R6 other bit", d, 32'h2);
        wr(5'h14, 32'h2);
        rd(5'h14, d); check("R6 clear", d, 0);
        wr(5'h04, 32'd2000);
        wr(5'h10, 32'd2000);
        tick_en = 1'b1;
        wr(5'h14, 32'h2);
        tick_en = 1'b0;
        rd(5'h14, d); check("R6 set wins", d, 32'h2);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(5'h1C, 32'h0);
        check("R7 masked", {27'd0, irq_any, irq_ch}, 0);
        wr(5'h1C, 32'h2);
        check("R7 enabled", {27'd0, irq_any, irq_ch}, 32'h12);
        wr(5'h1C, 32'hF);
        check("R7 all enabled", {27'd0, irq_any, irq_ch}, 32'h12);
        wr(5'h1C, 32'h0);
        rd(5'h14, d); check("R7 status kept", d, 32'h2);
        check("R7 remasked", {27'd0, irq_any, irq_ch}, 0);
    endtask

    task automatic t_watchdog;
        logic [31:0] d;
        int pulses;
        wr(5'h14, 32'hF);
        wr(5'h0C, 32'd3000);
        wr(5'h10, 32'd2990);
        pulses = 0;
        tick_en = 1'b1;
        repeat (14) begin
            @(negedge clk);
            if (wd_reset_req) pulses++;
        end
        tick_en = 1'b0;
        check("R9 disarmed", 32'(pulses), 0);
        rd(5'h14, d); check("R5 channel 3", d, 32'h8);
        wr(5'h18, 32'h1);
        rd(5'h18, d); check("R8 armed", d, 1);
        wr(5'h18, 32'h0);
        rd(5'h18, d); check("R8 sticky", d, 1);
        wr(5'h10, 32'd2990);
        ticks(10);
        check("R9 before", 32'(wd_reset_req), 0);
        ticks(1);
        check("R9 pulse", 32'(wd_reset_req), 1);
        @(negedge clk);
        check("R9 one cycle", 32'(wd_reset_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_compare_rw();
        t_counter();
        t_match();
        t_irq();
        t_watchdog();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog timeout got=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule